// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into characters. It samples the line on a 16x tick that the block receives as an input, so the divisor that makes the tick lives elsewhere. It confirms a start bit at the middle of its bit period, then samples each data bit, the optional parity bit and one or two stop bits at the middle of their bit periods. Data arrives least significant bit first.

Each character is reported by a one-clock `valid_o` pulse with the data byte and three tags: parity error, framing error and break. When a stop bit is sampled low, the receiver takes that low bit as the start of the next character and carries on without waiting for a falling edge. A line that stays low for longer than one whole character gives one zero character tagged as a break, however long it stays low. The receiver then waits for the line to go high before it looks for a new start bit.

The character format is set by static inputs. The data width runs from 5 to 8 bits, parity can be off, even or odd, and the frame has one or two stop bits.

Top module: `uart_rx`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `data_o`, `parity_err_o`, `frame_err_o` and `break_o` are all 0.
- R2: A low line seen on a tick starts a candidate start bit. The 8th tick of that candidate, counting the first low tick as 1, samples the line again. Low confirms the start. High drops the candidate without producing a character.
- R3: `data_bits_i` selects the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits are received LSB first into `data_o[0]` upward. Unused upper bits of `data_o` read 0.
- R4: With `parity_en_i` set, one parity bit follows the last data bit. `parity_odd_i`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets `parity_err_o` for that character. With `parity_en_i` clear, `parity_err_o` is 0.
- R5: A low sample in the first stop bit, or in the second stop bit when `two_stop_i` is 1, sets `frame_err_o` for that character.
- R6: After a framing error, the low stop sample stands as the confirmed start bit of the next character. Its data bits are sampled 16, 32, ... ticks later, with no new falling edge needed.
- R7: A character whose start, data, parity and first stop samples are all 0 gives one 00h character with `break_o`=1, `frame_err_o`=0 and `parity_err_o`=0, once the line has stayed low for one tick more than a full character time. A longer low period gives no further characters.
- R8: After a break character, no start bit is looked for until the line has been seen high. A character sent after the break is received normally.
- R9: If the line in an all-zero character with a low stop bit rises before the break limit, the result is a 00h character with `frame_err_o`=1 and `break_o`=0. The receiver then returns to idle.
- R10: `rxd_i` passes through a 2-flop synchronizer. A character's `valid_o` pulse lasts one clock, in the clock after the tick that decides it. `data_o` and the tags hold their values until the next pulse.
- R11: With `two_stop_i`=1, both stop bits are sampled and the character is reported after the second stop sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 16x oversampling enable, one clock wide |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| data_bits_i | input | 2 | Data width select, 5 + value |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| valid_o | output | 1 | One-clock character strobe |
| data_o | output | 8 | Received character, right-aligned |
| parity_err_o | output | 1 | Parity mismatch tag |
| frame_err_o | output | 1 | Low stop bit tag |
| break_o | output | 1 | Break character tag |

## Verification
A change on `rxd_i` reaches the sampling logic two clocks later. A result is due one clock after the tick that holds the deciding sample: the middle of the last stop bit, the first high tick while a break is pending, or the tick that crosses the break limit. A behavioural model in the bench follows this latency: a two-entry delay on the line plus per-tick counting. The model is compared with every output on the falling edge of each clock, away from the edge where the design updates. The bench also keeps a queue of the characters each stimulus should produce. The queue is checked in order when `valid_o` is seen, so missing or extra characters are caught as well as wrong tags.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_BRKW, ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  // idle-high line, so reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '1;
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         par_bit_i,
  input  logic         odd_i,
  input  logic         en_i,
  output logic         err_o
);
  assign err_o = en_i & (^data_i ^ par_bit_i ^ odd_i);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] nbits_sel_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       two_stop_i,
  output logic       valid_o,
  output rx_char_t   char_o
);
  localparam int unsigned MID   = OSR / 2 - 1;
  localparam int unsigned CNT_W = $clog2(2 * OSR);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              par_q, par_d;
  logic              zero_q, zero_d;
  logic              valid_q;
  rx_char_t          char_q;

  logic              dlv, dlv_ferr, dlv_brk, rearm;
  logic              bit_end, perr;
  logic [IDX_W-1:0]  last_idx;
  logic [CNT_W-1:0]  brk_last;

  assign bit_end  = (cnt_q == CNT_W'(OSR - 1));
  assign last_idx = IDX_W'(3'd4 + {1'b0, nbits_sel_i});
  // ticks past the stop sample until the low run exceeds one character
  assign brk_last = two_stop_i ? CNT_W'(2 * OSR - MID - 1) : CNT_W'(OSR - MID - 1);

  uart_rx_parity #(.W(DATA_W)) u_par (
    .data_i   (buf_q),
    .par_bit_i(par_q),
    .odd_i    (par_odd_i),
    .en_i     (par_en_i),
    .err_o    (perr)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    buf_d    = buf_q;
    par_d    = par_q;
    zero_d   = zero_q;
    dlv      = 1'b0;
    dlv_ferr = 1'b0;
    dlv_brk  = 1'b0;
    rearm    = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!rx_i) begin
            state_d = ST_START;
            cnt_d   = CNT_W'(1);
          end
        end
        ST_START: begin
          if (cnt_q == CNT_W'(MID)) begin
            if (!rx_i) rearm = 1'b1;
            else       state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            buf_d[idx_q] = rx_i;
            zero_d       = zero_q & ~rx_i;
            cnt_d        = '0;
            if (idx_q == last_idx) state_d = par_en_i ? ST_PAR : ST_STOP1;
            else                   idx_d   = idx_q + IDX_W'(1);
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            par_d   = rx_i;
            zero_d  = zero_q & ~rx_i;
            cnt_d   = '0;
            state_d = ST_STOP1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_STOP1: begin
          if (bit_end) begin
            cnt_d = '0;
            if (rx_i) begin
              if (two_stop_i) state_d = ST_STOP2;
              else begin
                dlv     = 1'b1;
                state_d = ST_IDLE;
              end
            end else if (zero_q) begin
              state_d = ST_BRKW;
            end else begin
              dlv      = 1'b1;
              dlv_ferr = 1'b1;
              rearm    = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_STOP2: begin
          if (bit_end) begin
            dlv = 1'b1;
            if (rx_i) state_d = ST_IDLE;
            else begin
              dlv_ferr = 1'b1;
              rearm    = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_BRKW: begin
          if (rx_i) begin
            dlv      = 1'b1;
            dlv_ferr = 1'b1;
            state_d  = ST_IDLE;
          end else if (cnt_q == brk_last) begin
            dlv     = 1'b1;
            dlv_brk = 1'b1;
            state_d = ST_HOLD;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (rx_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
      // low sample taken as a confirmed start bit
      if (rearm) begin
        state_d = ST_DATA;
        cnt_d   = '0;
        idx_d   = '0;
        buf_d   = '0;
        zero_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      buf_q   <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      buf_q   <= buf_d;
      par_q   <= par_d;
      zero_q  <= zero_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= dlv;
      if (dlv) begin
        char_q.data <= dlv_brk ? '0 : buf_q;
        char_q.perr <= dlv_brk ? 1'b0 : perr;
        char_q.ferr <= dlv_ferr;
        char_q.brk  <= dlv_brk;
      end
    end
  end

  assign valid_o = valid_q;
  assign char_o  = char_q;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        data_bits_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              two_stop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              break_o
);
  logic     rx_s;
  rx_char_t chr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  uart_rx_core #(.OSR(OSR)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rx_i       (rx_s),
    .nbits_sel_i(data_bits_i),
    .par_en_i   (parity_en_i),
    .par_odd_i  (parity_odd_i),
    .two_stop_i (two_stop_i),
    .valid_o    (valid_o),
    .char_o     (chr)
  );

  assign data_o       = chr.data;
  assign parity_err_o = chr.perr;
  assign frame_err_o  = chr.ferr;
  assign break_o      = chr.brk;
endmodule

// File: rtl/uart_rx_sva.sv
module uart_rx_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [1:0] data_bits_i,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic       parity_err_o,
  input logic       frame_err_o,
  input logic       break_o
);
  logic [7:0] width_mask;
  assign width_mask = 8'hFF >> (2'd3 - data_bits_i);

  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_after_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o) && $stable(frame_err_o) && $stable(break_o));

  p_break_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && break_o |-> data_o == 8'h00 && !frame_err_o && !parity_err_o);

  p_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o & ~width_mask) == 8'h00);
endmodule

bind uart_rx uart_rx_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .data_bits_i (data_bits_i),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .parity_err_o(parity_err_o),
  .frame_err_o (frame_err_o),
  .break_o     (break_o)
);

// File: tb/uart_rx_tb_top.sv
`timescale 1ns/1ps
module uart_rx_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT      = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] dbits = 2'd3;
  logic       pen = 1'b0, podd = 1'b0, two = 1'b0;
  logic       valid, perr, ferr, brk;
  logic [7:0] data;

  int n_checks = 0, n_fail = 0, cycles = 0, tick_cnt = 0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  uart_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .data_bits_i(dbits), .parity_en_i(pen), .parity_odd_i(podd), .two_stop_i(two),
    .valid_o(valid), .data_o(data), .parity_err_o(perr), .frame_err_o(ferr), .break_o(brk)
  );

  always @(negedge clk) begin
    tick = (tick_cnt == TICK_DIV - 1);
    tick_cnt = (tick_cnt + 1) % TICK_DIV;
  end

  // ---------------- behavioural reference model ----------------
  int m_mode, m_ticks, m_bitno, m_buf, m_par, m_allzero, m_s1, m_s2;
  int m_valid, m_data, m_perr, m_ferr, m_brk;

  task automatic m_emit(input int f, input int b);
    m_valid = 1;
    m_data  = b ? 0 : m_buf;
    m_perr  = (!b && pen) ? (($countones(m_buf) + m_par + podd) % 2) : 0;
    m_ferr  = f;
    m_brk   = b;
  endtask

  task automatic m_restart();
    m_mode = 2; m_ticks = 0; m_bitno = 0; m_buf = 0; m_allzero = 1;
  endtask

  always @(posedge clk) begin
    int s;
    if (!rst_n) begin
      m_mode = 0; m_ticks = 0; m_bitno = 0; m_buf = 0; m_par = 0; m_allzero = 1;
      m_s1 = 1; m_s2 = 1;
      m_valid = 0; m_data = 0; m_perr = 0; m_ferr = 0; m_brk = 0;
    end else begin
      s = m_s2;
      m_valid = 0;
      if (tick) begin
        case (m_mode)
          0: if (s == 0) begin m_mode = 1; m_ticks = 1; end
          1: if (m_ticks == 7) begin
               if (s == 0) m_restart(); else m_mode = 0;
             end else m_ticks++;
          2: if (m_ticks == 15) begin
               m_buf |= s << m_bitno;
               if (s) m_allzero = 0;
               m_ticks = 0;
               if (m_bitno == 4 + dbits) m_mode = pen ? 3 : 4; else m_bitno++;
             end else m_ticks++;
          3: if (m_ticks == 15) begin
               m_par = s; if (s) m_allzero = 0; m_ticks = 0; m_mode = 4;
             end else m_ticks++;
          4: if (m_ticks == 15) begin
               m_ticks = 0;
               if (s) begin
                 if (two) m_mode = 5; else begin m_emit(0, 0); m_mode = 0; end
               end else if (m_allzero) m_mode = 6;
               else begin m_emit(1, 0); m_restart(); end
             end else m_ticks++;
          5: if (m_ticks == 15) begin
               if (s) begin m_emit(0, 0); m_mode = 0; end
               else begin m_emit(1, 0); m_restart(); end
             end else m_ticks++;
          6: if (s) begin m_emit(1, 0); m_mode = 0; end
             else if (m_ticks == (two ? 24 : 8)) begin m_emit(0, 1); m_mode = 7; end
             else m_ticks++;
          default: if (s) m_mode = 0;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = rxd;
    end
  end

  // ---------------- checks ----------------
  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(valid == m_valid[0] && data == m_data[7:0] && perr == m_perr[0] &&
          ferr == m_ferr[0] && brk == m_brk[0], "R10 cycle model",
          $sformatf("v%0d d%02h p%0d f%0d b%0d", valid, data, perr, ferr, brk),
          $sformatf("v%0d d%02h p%0d f%0d b%0d", m_valid, m_data, m_perr, m_ferr, m_brk));
      if (valid) begin
        int got;
        got = {brk, ferr, perr, data};
        if (exp_q.size() == 0)
          chk(1'b0, "R2 unexpected char", $sformatf("%03h", got), "none");
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(got == e, t, $sformatf("%03h", got), $sformatf("%03h", e));
        end
      end
    end
  end

  task automatic expect_char(input int d, input int p, input int f, input int b, input string t);
    exp_q.push_back((b << 10) | (f << 9) | (p << 8) | d);
    tag_q.push_back(t);
  endtask

  task automatic drive(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = bits[i];
      repeat (BIT) @(negedge clk);
    end
  endtask

  task automatic idle(input int nb);
    rxd = 1'b1;
    repeat (nb * BIT) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic pe, input logic od, input logic ts);
    @(negedge clk);
    dbits = sel; pen = pe; podd = od; two = ts;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while in reset
    chk(valid == 0 && data == 0 && perr == 0 && ferr == 0 && brk == 0, "R1 reset",
        $sformatf("v%0d d%02h p%0d f%0d b%0d", valid, data, perr, ferr, brk), "all zero");
    rst_n = 1'b1;
    idle(3);

    // R3: 8N1 and 5N1
    expect_char(8'hA5, 0, 0, 0, "R3 8-bit");
    drive({1'b1, 8'hA5, 1'b0}, 10); idle(2);
    cfg(2'd0, 0, 0, 0);
    expect_char(8'h13, 0, 0, 0, "R3 5-bit");
    drive({1'b1, 5'h13, 1'b0}, 7); idle(2);

    // R4: even then odd parity
    cfg(2'd2, 1, 0, 0);
    expect_char(8'h55, 0, 0, 0, "R4 even ok");
    drive({1'b1, 1'b0, 7'h55, 1'b0}, 10); idle(2);
    expect_char(8'h55, 1, 0, 0, "R4 even bad");
    drive({1'b1, 1'b1, 7'h55, 1'b0}, 10); idle(2);
    cfg(2'd1, 1, 1, 0);
    expect_char(8'h2A, 0, 0, 0, "R4 odd ok");
    drive({1'b1, 1'b0, 6'h2A, 1'b0}, 9); idle(2);
    expect_char(8'h00, 1, 0, 0, "R4 odd bad");
    drive({1'b1, 1'b0, 6'h00, 1'b0}, 9); idle(2);

    // R2: short low pulse ignored, then a real char
    cfg(2'd3, 0, 0, 0);
    rxd = 1'b0; repeat (3 * TICK_DIV) @(negedge clk);
    idle(3);
    expect_char(8'h3C, 0, 0, 0, "R2 after glitch");
    drive({1'b1, 8'h3C, 1'b0}, 10); idle(2);

    // R11 two stop bits; R5/R6 low second stop then idle line resyncs into FFh
    cfg(2'd3, 0, 0, 1);
    expect_char(8'hC3, 0, 0, 0, "R11 two stop");
    drive({2'b11, 8'hC3, 1'b0}, 11); idle(2);
    expect_char(8'h81, 0, 1, 0, "R5 second stop low");
    expect_char(8'hFF, 0, 0, 0, "R6 resync on idle line");
    drive({1'b0, 1'b1, 8'h81, 1'b0}, 11); idle(13);

    // R5/R6: low stop directly followed by next char's data
    cfg(2'd3, 0, 0, 0);
    expect_char(8'h3C, 0, 1, 0, "R5 stop low");
    expect_char(8'h5A, 0, 0, 0, "R6 resync data");
    drive({1'b1, 8'h5A, 1'b0, 8'h3C, 1'b0}, 19); idle(2);

    // R9: all-zero char, line rises right after the low stop bit
    expect_char(8'h00, 0, 1, 0, "R9 short low");
    drive({1'b1, 1'b0, 8'h00, 1'b0}, 11); idle(2);

    // R7/R8: long break, then a normal char
    expect_char(8'h00, 0, 0, 1, "R7 break");
    rxd = 1'b0; repeat (30 * BIT) @(negedge clk);
    idle(2);
    expect_char(8'h96, 0, 0, 0, "R8 after break");
    drive({1'b1, 8'h96, 1'b0}, 10); idle(3);

    chk(exp_q.size() == 0, "R7 all expected chars seen",
        $sformatf("%0d left", exp_q.size()), "0 left");
    finish_run();
  end
endmodule